// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block holds the two debug data registers through which an external debug host drives a halted core over a JTAG TAP. The instruction chain lets the host load a 32-bit core instruction and read back whether the last injected instruction has finished. The data chain moves 32-bit words in either direction, with each scan carrying its own handshake bits so the host can tell whether the transfer was accepted.

The block sits beside a TAP controller. It takes the controller's capture, shift and update strobes, a level that is high while the controller is in Run-Test/Idle, the selected chain number and the current instruction code. An injected instruction is handed to the core only on a fresh entry into Run-Test/Idle, through a valid/ready request with a separate completion pulse. Two single-word mailboxes, each with a full flag, carry data: host-to-core (drained by a take strobe from the core) and core-to-host (filled by a load strobe from the core). Executing the instruction is the core's job, not this block's.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset, `iss_valid`, `h2c_full` and `c2h_full` are 0 and the completion flag reads 1.
- R2: The instruction chain is 33 bits, shifted least significant bit first: bits 0 to 31 are the instruction, bit 32 is the completion flag. A capture loads the last loaded instruction and the flag; an update loads bits 0 to 31 as the instruction, and the next issue presents it on `iss_instr`.
- R3: The instruction chain is selected by instruction code 5'h1E on any chain, or by code 5'h00 (write) or 5'h0C (read) with chain 4. On the first cycle `idle_in` is high after being low, an issue starts if the code is 5'h1E, or the code is 5'h00 or 5'h0C with chain 4 or 5; otherwise nothing is issued. `iss_valid` rises one cycle after that entry.
- R4: Staying in Run-Test/Idle for several cycles issues at most once; leaving and re-entering issues again.
- R5: `iss_valid` and `iss_instr` hold until a cycle with `iss_ready` high, after which `iss_valid` is 0. An entry into Run-Test/Idle while a request is outstanding is discarded.
- R6: The completion flag is cleared when an issue starts and set by an `iss_done` pulse.
- R7: With chain 5 selected, the data chain is 34 bits, shifted least significant bit first: bits 0 to 31 data, bit 32 Ready, bit 33 nRetry. An update under code 5'h00 loads the word into the host-to-core mailbox and sets `h2c_full` when the mailbox is empty; `h2c_take` clears `h2c_full`.
- R8: An update under code 5'h00 while `h2c_full` is set leaves the mailbox unchanged and makes later write captures read nRetry as 0, until a write update is accepted.
- R9: A write capture reads Ready as 1 only when the host-to-core mailbox is empty and the completion flag is set.
- R10: `c2h_load` stores `c2h_data` and sets `c2h_full`. A capture under code 5'h0C on chain 5 returns the stored word, Ready equal to `c2h_full`, nRetry 1, and clears `c2h_full`.
- R11: An update under the read code 5'h0C does not change the host-to-core mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_code | input | 5 | Current TAP instruction code |
| chain_sel | input | 5 | Selected scan chain number |
| capture_dr | input | 1 | Capture strobe for the selected chain |
| shift_dr | input | 1 | Shift strobe for the selected chain |
| update_dr | input | 1 | Update strobe for the selected chain |
| idle_in | input | 1 | High while the TAP is in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out from the selected chain |
| iss_valid | output | 1 | Instruction request to the core |
| iss_ready | input | 1 | Core accepts the request |
| iss_instr | output | 32 | Instruction being issued |
| iss_done | input | 1 | Core pulse: injected instruction finished |
| h2c_data | output | 32 | Host-to-core mailbox word |
| h2c_full | output | 1 | Host-to-core mailbox holds a word |
| h2c_take | input | 1 | Core consumes the host-to-core word |
| c2h_data | input | 32 | Word offered by the core |
| c2h_load | input | 1 | Core writes the core-to-host mailbox |
| c2h_full | output | 1 | Core-to-host mailbox holds a word |

## Verification
The assertions assume a well-behaved TAP and core: at most one of the capture, shift and update strobes is high in any cycle, the core pulses `h2c_take` only while `h2c_full` is set, and it pulses `c2h_load` only while `c2h_full` is clear. The bench drives the strobes from a single scan task that raises them one at a time, and its core stub takes the mailbox and loads the return word only after checking the matching full flag at the ports. The stub's completion latency is adjustable so that captures can be made both before and after `iss_done`.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
  // Instruction codes that route scans to the transfer chains
  localparam int CODE_WRITE = 'h00;
  localparam int CODE_READ  = 'h0C;
  localparam int CODE_INSN  = 'h1E;
  // Chain numbers
  localparam int CHAIN_INSN = 4;
  localparam int CHAIN_DATA = 5;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_INSN,
    PATH_DATA_WR,
    PATH_DATA_RD
  } path_e;
endpackage

// File: rtl/dbg_xfer_sel.sv
module dbg_xfer_sel
  import dbg_xfer_pkg::*;
#(
  parameter int IR_W  = 5,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IR_W-1:0]  ir_code,
  input  logic [SEL_W-1:0] chain_sel,
  input  logic             idle_in,
  output path_e            path,
  output logic             issue_req
);
  localparam logic [IR_W-1:0]  K_WR   = IR_W'(CODE_WRITE);
  localparam logic [IR_W-1:0]  K_RD   = IR_W'(CODE_READ);
  localparam logic [IR_W-1:0]  K_INSN = IR_W'(CODE_INSN);
  localparam logic [SEL_W-1:0] K_CI   = SEL_W'(CHAIN_INSN);
  localparam logic [SEL_W-1:0] K_CD   = SEL_W'(CHAIN_DATA);

  logic idle_q;
  logic is_rw;
  logic armed;

  // Previous idle level; reset to 1 so no issue fires right after reset
  always_ff @(posedge clk) begin
    if (rst) idle_q <= 1'b1;
    else     idle_q <= idle_in;
  end

  assign is_rw = (ir_code == K_WR) || (ir_code == K_RD);
  assign armed = (ir_code == K_INSN) ||
                 (is_rw && ((chain_sel == K_CI) || (chain_sel == K_CD)));
  assign issue_req = armed && idle_in && !idle_q;

  always_comb begin
    path = PATH_NONE;
    if (ir_code == K_INSN)                         path = PATH_INSN;
    else if (is_rw && chain_sel == K_CI)           path = PATH_INSN;
    else if (ir_code == K_WR && chain_sel == K_CD) path = PATH_DATA_WR;
    else if (ir_code == K_RD && chain_sel == K_CD) path = PATH_DATA_RD;
  end
endmodule

// File: rtl/dbg_xfer_insn.sv
module dbg_xfer_insn #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_me,
  input  logic              cap,
  input  logic              sh,
  input  logic              upd,
  input  logic              tdi,
  input  logic              issue_req,
  input  logic              iss_ready,
  input  logic              iss_done,
  output logic              tdo_bit,
  output logic              iss_valid,
  output logic [WORD_W-1:0] iss_instr,
  output logic              done_flag
);
  localparam int LEN = WORD_W + 1;

  logic [LEN-1:0]    sr;
  logic [WORD_W-1:0] loaded;
  logic              start;
  logic              unused_flag_in;

  // An entry while a request is outstanding is dropped
  assign start = issue_req && !iss_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      loaded    <= '0;
      iss_instr <= '0;
      iss_valid <= 1'b0;
      done_flag <= 1'b1;
    end else begin
      if (sel_me && cap)     sr <= {done_flag, loaded};
      else if (sel_me && sh) sr <= {tdi, sr[LEN-1:1]};

      if (sel_me && upd) loaded <= sr[WORD_W-1:0];

      if (start) begin
        iss_valid <= 1'b1;
        iss_instr <= loaded;
      end else if (iss_valid && iss_ready) begin
        iss_valid <= 1'b0;
      end

      if (start)         done_flag <= 1'b0;
      else if (iss_done) done_flag <= 1'b1;
    end
  end

  assign tdo_bit        = sr[0];
  assign unused_flag_in = sr[LEN-1];
endmodule

// File: rtl/dbg_xfer_data.sv
module dbg_xfer_data #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic              sel_rd,
  input  logic              cap,
  input  logic              sh,
  input  logic              upd,
  input  logic              tdi,
  input  logic              done_flag,
  input  logic              h2c_take,
  input  logic              c2h_load,
  input  logic [WORD_W-1:0] c2h_in,
  output logic              tdo_bit,
  output logic [WORD_W-1:0] h2c_data,
  output logic              h2c_full,
  output logic              c2h_full
);
  localparam int LEN = WORD_W + 2;

  logic [LEN-1:0]    sr;
  logic [WORD_W-1:0] c2h_q;
  logic              refused;
  logic              wr_upd;
  logic              sel_any;
  logic [1:0]        unused_hs;

  assign sel_any = sel_wr || sel_rd;
  assign wr_upd  = sel_wr && upd;

  // Shift register: capture builds {nRetry, Ready, word}
  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (sel_wr && cap) begin
      sr <= {~refused, (~h2c_full) & done_flag, h2c_data};
    end else if (sel_rd && cap) begin
      sr <= {1'b1, c2h_full, c2h_q};
    end else if (sel_any && sh) begin
      sr <= {tdi, sr[LEN-1:1]};
    end
  end

  // Host-to-core mailbox
  always_ff @(posedge clk) begin
    if (rst) begin
      h2c_data <= '0;
      h2c_full <= 1'b0;
      refused  <= 1'b0;
    end else begin
      if (wr_upd && !h2c_full) begin
        h2c_data <= sr[WORD_W-1:0];
        h2c_full <= 1'b1;
        refused  <= 1'b0;
      end else begin
        if (wr_upd)   refused  <= 1'b1;
        if (h2c_take) h2c_full <= 1'b0;
      end
    end
  end

  // Core-to-host mailbox
  always_ff @(posedge clk) begin
    if (rst) begin
      c2h_q    <= '0;
      c2h_full <= 1'b0;
    end else if (c2h_load) begin
      c2h_q    <= c2h_in;
      c2h_full <= 1'b1;
    end else if (sel_rd && cap) begin
      c2h_full <= 1'b0;
    end
  end

  assign tdo_bit   = sr[0];
  assign unused_hs = sr[LEN-1:WORD_W];
endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains
  import dbg_xfer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IR_W   = 5,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   ir_code,
  input  logic [SEL_W-1:0]  chain_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              idle_in,
  input  logic              tdi,
  output logic              tdo,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [WORD_W-1:0] iss_instr,
  input  logic              iss_done,
  output logic [WORD_W-1:0] h2c_data,
  output logic              h2c_full,
  input  logic              h2c_take,
  input  logic [WORD_W-1:0] c2h_data,
  input  logic              c2h_load,
  output logic              c2h_full
);
  path_e path;
  logic  issue_req;
  logic  done_flag;
  logic  tdo_insn;
  logic  tdo_data;

  dbg_xfer_sel #(.IR_W(IR_W), .SEL_W(SEL_W)) sel_i (
    .clk       (clk),
    .rst       (rst),
    .ir_code   (ir_code),
    .chain_sel (chain_sel),
    .idle_in   (idle_in),
    .path      (path),
    .issue_req (issue_req)
  );

  dbg_xfer_insn #(.WORD_W(WORD_W)) insn_i (
    .clk       (clk),
    .rst       (rst),
    .sel_me    (path == PATH_INSN),
    .cap       (capture_dr),
    .sh        (shift_dr),
    .upd       (update_dr),
    .tdi       (tdi),
    .issue_req (issue_req),
    .iss_ready (iss_ready),
    .iss_done  (iss_done),
    .tdo_bit   (tdo_insn),
    .iss_valid (iss_valid),
    .iss_instr (iss_instr),
    .done_flag (done_flag)
  );

  dbg_xfer_data #(.WORD_W(WORD_W)) data_i (
    .clk       (clk),
    .rst       (rst),
    .sel_wr    (path == PATH_DATA_WR),
    .sel_rd    (path == PATH_DATA_RD),
    .cap       (capture_dr),
    .sh        (shift_dr),
    .upd       (update_dr),
    .tdi       (tdi),
    .done_flag (done_flag),
    .h2c_take  (h2c_take),
    .c2h_load  (c2h_load),
    .c2h_in    (c2h_data),
    .tdo_bit   (tdo_data),
    .h2c_data  (h2c_data),
    .h2c_full  (h2c_full),
    .c2h_full  (c2h_full)
  );

  always_comb begin
    case (path)
      PATH_INSN:                 tdo = tdo_insn;
      PATH_DATA_WR, PATH_DATA_RD: tdo = tdo_data;
      default:                   tdo = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_xfer_chains_chk.sv
module dbg_xfer_chains_chk #(
  parameter int WORD_W = 32,
  parameter int IR_W   = 5,
  parameter int SEL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [IR_W-1:0]   ir_code,
  input logic [SEL_W-1:0]  chain_sel,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              idle_in,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [WORD_W-1:0] iss_instr,
  input logic [WORD_W-1:0] h2c_data,
  input logic              h2c_full,
  input logic              h2c_take,
  input logic              c2h_load,
  input logic              c2h_full
);
  localparam logic [IR_W-1:0]  K_RD = IR_W'(dbg_xfer_pkg::CODE_READ);
  localparam logic [SEL_W-1:0] K_CD = SEL_W'(dbg_xfer_pkg::CHAIN_DATA);

  // Input expectations
  AST_IN_STROBES: assert property (@(posedge clk) disable iff (rst)
    $onehot0({capture_dr, shift_dr, update_dr}));                      // R2
  AST_IN_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
    h2c_take |-> h2c_full);                                            // R7
  AST_IN_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    c2h_load |-> !c2h_full);                                           // R10

  // Block behaviour
  AST_FRESH_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) |-> $past(idle_in) && !$past(idle_in, 2));        // R4
  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_instr));      // R5
  AST_ISSUE_DROP: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_ready |=> !iss_valid);                            // R5
  AST_H2C_HOLD: assert property (@(posedge clk) disable iff (rst)
    h2c_full && !h2c_take |=> h2c_full && $stable(h2c_data));          // R8
  AST_H2C_FILL: assert property (@(posedge clk) disable iff (rst)
    $rose(h2c_full) |-> $past(update_dr));                             // R7
  AST_C2H_SET: assert property (@(posedge clk) disable iff (rst)
    c2h_load |=> c2h_full);                                            // R10
  AST_C2H_DRAIN: assert property (@(posedge clk) disable iff (rst)
    $fell(c2h_full) |-> $past(capture_dr) && $past(ir_code) == K_RD
                        && $past(chain_sel) == K_CD);                  // R10
endmodule

bind dbg_xfer_chains dbg_xfer_chains_chk #(
  .WORD_W(WORD_W), .IR_W(IR_W), .SEL_W(SEL_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ir_code    (ir_code),
  .chain_sel  (chain_sel),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .idle_in    (idle_in),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_instr  (iss_instr),
  .h2c_data   (h2c_data),
  .h2c_full   (h2c_full),
  .h2c_take   (h2c_take),
  .c2h_load   (c2h_load),
  .c2h_full   (c2h_full)
);

// File: tb/dbg_xfer_chains_tb_top.sv
module dbg_xfer_chains_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ir_code = 5'h1E;
  logic [4:0]  chain_sel = 5'd0;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic        idle_in = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        iss_valid;
  logic        iss_ready = 1'b1;
  logic [31:0] iss_instr;
  logic        iss_done = 1'b0;
  logic [31:0] h2c_data;
  logic        h2c_full;
  logic        h2c_take = 1'b0;
  logic [31:0] c2h_data = '0;
  logic        c2h_load = 1'b0;
  logic        c2h_full;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Core stub
  int          issues = 0;
  logic [31:0] last_issued = '0;
  int          done_cnt = 0;
  int          stub_lat = 4;

  always #10 clk = ~clk;

  dbg_xfer_chains dut_i (
    .clk(clk), .rst(rst), .ir_code(ir_code), .chain_sel(chain_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .idle_in(idle_in), .tdi(tdi), .tdo(tdo),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_instr(iss_instr),
    .iss_done(iss_done), .h2c_data(h2c_data), .h2c_full(h2c_full),
    .h2c_take(h2c_take), .c2h_data(c2h_data), .c2h_load(c2h_load),
    .c2h_full(c2h_full)
  );

  always @(negedge clk) begin
    iss_done = 1'b0;
    if (done_cnt > 0) begin
      done_cnt = done_cnt - 1;
      if (done_cnt == 0) iss_done = 1'b1;
    end
    if (iss_valid && iss_ready) begin
      issues      = issues + 1;
      last_issued = iss_instr;
      done_cnt    = stub_lat;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scan(input int n, input logic [33:0] din,
                      output logic [33:0] dout, input bit go_idle);
    dout = '0;
    @(negedge clk); capture_dr = 1'b1;
    @(negedge clk); capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1;
      tdi      = din[i];
      dout[i]  = tdo;
      @(negedge clk);
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(negedge clk); update_dr = 1'b0;
    if (go_idle) begin
      idle_in = 1'b1;
      repeat (6) @(negedge clk);
      idle_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle_visit(input int cycles);
    @(negedge clk); idle_in = 1'b1;
    repeat (cycles) @(negedge clk);
    idle_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [33:0] d;
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 h2c_full", h2c_full, 0);
    chk("R1 c2h_full", c2h_full, 0);
    ir_code = 5'h1E;
    scan(33, 34'h0, d, 0);
    chk("R1 completion flag", d[32], 1);
  endtask

  task automatic t_issue_once();
    logic [33:0] d;
    int b;
    ir_code = 5'h1E; chain_sel = 5'd0;
    b = issues;
    scan(33, {2'b00, 32'hE3A0_1005}, d, 1);
    chk("R4 single issue while idle", issues, b + 1);
    chk("R2 issued instruction", last_issued, 32'hE3A0_1005);
    b = issues;
    idle_visit(3);
    idle_visit(5);
    chk("R4 re-entry issues again", issues, b + 2);
    settle();
  endtask

  task automatic t_flag();
    logic [33:0] d;
    ir_code = 5'h1E;
    stub_lat = 40;
    scan(33, {2'b00, 32'h1234_ABCD}, d, 1);
    scan(33, {2'b00, 32'h1234_ABCD}, d, 0);
    chk("R6 flag cleared on issue", d[32], 0);
    chk("R2 captured instruction", d[31:0], 32'h1234_ABCD);
    settle();
    scan(33, {2'b00, 32'h1234_ABCD}, d, 0);
    chk("R6 flag set by done", d[32], 1);
    stub_lat = 4;
  endtask

  task automatic t_gate();
    int b;
    b = issues;
    ir_code = 5'h00; chain_sel = 5'd0;
    idle_visit(4);
    chk("R3 no issue on chain 0", issues, b);
    ir_code = 5'h00; chain_sel = 5'd5;
    idle_visit(4);
    chk("R3 issue on chain 5 write", issues, b + 1);
    ir_code = 5'h0C; chain_sel = 5'd4;
    idle_visit(4);
    chk("R3 issue on chain 4 read", issues, b + 2);
    ir_code = 5'h0C; chain_sel = 5'd7;
    idle_visit(4);
    chk("R3 no issue on chain 7", issues, b + 2);
    settle();
  endtask

  task automatic t_hold();
    int b;
    b = issues;
    ir_code = 5'h1E;
    iss_ready = 1'b0;
    idle_visit(3);
    idle_visit(3);
    chk("R5 valid held without ready", iss_valid, 1);
    chk("R5 no transfer without ready", issues, b);
    iss_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 one transfer after ready", issues, b + 1);
    chk("R5 valid drops", iss_valid, 0);
    settle();
  endtask

  task automatic t_write();
    logic [33:0] d;
    ir_code = 5'h00; chain_sel = 5'd5;
    scan(34, {2'b00, 32'h1234_5678}, d, 0);
    chk("R9 ready when empty", d[32], 1);
    chk("R8 nRetry high at start", d[33], 1);
    chk("R7 h2c_full set", h2c_full, 1);
    chk("R7 h2c_data", h2c_data, 32'h1234_5678);
    scan(34, {2'b00, 32'hDEAD_BEEF}, d, 0);
    chk("R9 ready low when full", d[32], 0);
    chk("R8 data kept on refusal", h2c_data, 32'h1234_5678);
    scan(34, {2'b00, 32'hDEAD_BEEF}, d, 0);
    chk("R8 nRetry low after refusal", d[33], 0);
    @(negedge clk); if (h2c_full) h2c_take = 1'b1;
    @(negedge clk); h2c_take = 1'b0;
    chk("R7 take clears full", h2c_full, 0);
    scan(34, {2'b00, 32'hCAFE_0001}, d, 0);
    chk("R8 nRetry stays low until accepted", d[33], 0);
    chk("R9 ready after take", d[32], 1);
    chk("R7 second word", h2c_data, 32'hCAFE_0001);
    scan(34, {2'b00, 32'hCAFE_0002}, d, 0);
    chk("R8 nRetry high after accept", d[33], 1);
    @(negedge clk); if (h2c_full) h2c_take = 1'b1;
    @(negedge clk); h2c_take = 1'b0;
    stub_lat = 40;
    idle_visit(2);
    scan(34, {2'b00, 32'h0000_00F0}, d, 0);
    chk("R9 ready low while instruction runs", d[32], 0);
    @(negedge clk); if (h2c_full) h2c_take = 1'b1;
    @(negedge clk); h2c_take = 1'b0;
    stub_lat = 4;
    settle();
  endtask

  task automatic t_read();
    logic [33:0] d;
    logic [31:0] keep;
    keep = h2c_data;
    ir_code = 5'h0C; chain_sel = 5'd5;
    @(negedge clk);
    if (!c2h_full) begin c2h_data = 32'hA5A5_0F0F; c2h_load = 1'b1; end
    @(negedge clk); c2h_load = 1'b0;
    chk("R10 load sets full", c2h_full, 1);
    scan(34, {2'b00, 32'h7777_7777}, d, 0);
    chk("R10 read word", d[31:0], 32'hA5A5_0F0F);
    chk("R10 ready when full", d[32], 1);
    chk("R10 nRetry high on read", d[33], 1);
    chk("R10 capture clears full", c2h_full, 0);
    chk("R11 read update leaves h2c_full", h2c_full, 0);
    chk("R11 read update leaves h2c_data", h2c_data, keep);
    scan(34, 34'h0, d, 0);
    chk("R10 ready low when empty", d[32], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_issue_once();
    t_flag();
    t_gate();
    t_hold();
    t_write();
    t_read();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule